// File: doc/BRIEF.md
# Dual-Mode Color Lookup Datapath

This block is the pixel side of a 24-bit color lookup table. Three 8-bit memory banks, one per output channel, are read once per pixel clock. In index mode the low bits of the pixel word form one shared index, and the three banks together return one palette color. In true-color mode each input byte addresses its own bank through one of three gamma tables that a 2-bit select picks. The looked-up color leaves through a registered 24-bit output three clocks after the pixel entered.

A 4-bit synchronization sideband travels beside the color with the same delay. A command mask can force its low half to zero and its high half to one. The host side, which stands for the microprocessor decode and the write FIFO, reaches the banks through a single read/write port that always wins over the pixel stream. While the host owns the banks, or while it raises a separate hold request, the output stays on the color of the last valid pixel lookup.

The port arbiter is a three-state machine. The states are PIXEL (the pixel stream reads the banks), HOST (the host port reads or writes them) and HOLD (nobody reads, and the output is frozen). From any state, a host request moves it to HOST. With no host request, a hold request moves it to HOLD. With neither request, it returns to PIXEL.

Top module: `clut_datapath`

## Requirements
- R1: While reset is asserted, `pix_out`, `sync_out` and `host_rdata` are all zero.
- R2: With `true_mode`=0, the index is `pix_in[ADDR_W-1:0]`, and `pix_out` = {bank2[idx], bank1[idx], bank0[idx]}. Pixel bits at ADDR_W and above have no effect.
- R3: With `true_mode`=1, channel c (0 = bits 7:0, 1 = bits 15:8, 2 = bits 23:16) of `pix_out` is bank c read at address {tsel, zero padding, byte c of `pix_in`}. The 2-bit table select sits in the top two address bits.
- R4: A `tbl_sel` value of 3 gives the same lookup as table 0.
- R5: A pixel and its sideband, presented before clock edge k, appear on `pix_out` and `sync_out` just after edge k+2, which is a latency of three clocks.
- R6: Sideband bits 0 and 1 are ANDed with `sync_force` bits 0 and 1. Bits 2 and 3 are ORed with `sync_force` bits 2 and 3. The mask in force at the input edge is the one that applies.
- R7: A host request always takes the bank port in the same cycle, even when `hold_req` is also high. With `host_we`=1, it writes `host_wdata` (bytes in channel order) into all three banks at `host_addr`.
- R8: A host read at edge k (`host_req`=1, `host_we`=0) places the addressed 24-bit word on `host_rdata` after edge k+1. At other times `host_rdata` keeps its value.
- R9: While the host owns the bank port, `pix_out` holds the color of the last valid pixel lookup.
- R10: While `hold_req` is high, the banks are not read for pixels and `pix_out` holds its value.
- R11: Two clocks after the host request and the hold request are both released, `pix_out` shows the lookup of the pixel currently held on the input.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pix_in | input | 24 | Pixel word |
| true_mode | input | 1 | 0 = shared index, 1 = per-channel gamma |
| tbl_sel | input | 2 | Gamma table select (3 acts as 0) |
| sync_in | input | SB_W | Synchronization sideband in |
| sync_force | input | SB_W | Command force mask for the sideband |
| host_req | input | 1 | Host claims the bank port this cycle |
| host_we | input | 1 | Host write (1) or read (0) |
| host_addr | input | ADDR_W | Host bank address |
| host_wdata | input | 24 | Host write word |
| host_rdata | output | 24 | Host read word |
| hold_req | input | 1 | Freeze the pixel output without a bank access |
| pix_out | output | 24 | Looked-up color |
| sync_out | output | SB_W | Delayed, forced sideband |

## Verification
The banks are first filled with a word that differs per bank and per address. A wrong bank, a swapped byte lane or a misplaced table-select field then shows up as a wrong color. Index-mode vectors use the all-ones index and an index with bits set above ADDR_W, which separates correct index truncation from aliasing. True-color vectors walk tables 0, 1, 2 and 3 with distinct bytes per lane, so they show whether the lanes are independent and whether table 3 folds onto table 0. Sideband vectors pair each sideband value with masks that both force and pass bits, which shows the AND half and the OR half separately. Directed runs of host access and hold, done with a new pixel already waiting on the input, show whether the output stays frozen and whether the resume comes after exactly two clocks.

// File: rtl/clut_pkg.sv
package clut_pkg;
    localparam int CHAN_W   = 8;
    localparam int NUM_CHAN = 3;
    localparam int SEL_W    = 2;
    localparam int PIX_W    = CHAN_W * NUM_CHAN;

    typedef enum logic [1:0] {
        OWN_PIXEL = 2'd0,
        OWN_HOST  = 2'd1,
        OWN_HOLD  = 2'd2
    } owner_e;
endpackage

// File: rtl/clut_arbiter.sv
module clut_arbiter
    import clut_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic host_req,
    input  logic hold_req,
    output logic pix_gnt,
    output logic host_gnt,
    output logic read_valid
);
    owner_e st_q, st_d;

    // next owner of the bank port; host has priority
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            OWN_PIXEL: begin
                if (host_req)      st_d = OWN_HOST;
                else if (hold_req) st_d = OWN_HOLD;
            end
            OWN_HOST: begin
                if (!host_req)     st_d = hold_req ? OWN_HOLD : OWN_PIXEL;
            end
            OWN_HOLD: begin
                if (host_req)      st_d = OWN_HOST;
                else if (!hold_req) st_d = OWN_PIXEL;
            end
            default:               st_d = OWN_PIXEL;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= OWN_PIXEL;
        else        st_q <= st_d;
    end

    always_comb begin
        pix_gnt    = (st_d == OWN_PIXEL);
        host_gnt   = (st_d == OWN_HOST);
        read_valid = (st_q == OWN_PIXEL);
    end

    a_r7_host_first: assert property (@(posedge clk) disable iff (!rst_n)
        host_req |-> (host_gnt && !pix_gnt))
        else $error("host request not granted first");

    a_r10_hold_blocks: assert property (@(posedge clk) disable iff (!rst_n)
        hold_req |=> !read_valid)
        else $error("pixel read marked valid during hold");
endmodule

// File: rtl/clut_addr_gen.sv
module clut_addr_gen
    import clut_pkg::*;
#(
    parameter int ADDR_W = 11
) (
    input  logic [PIX_W-1:0]  pix,
    input  logic              true_mode,
    input  logic [SEL_W-1:0]  tsel,
    output logic [ADDR_W-1:0] bank_addr [NUM_CHAN]
);
    localparam int PAD_W = ADDR_W - SEL_W - CHAN_W;

    logic [SEL_W-1:0] tsel_eff;
    assign tsel_eff = (tsel == 2'd3) ? 2'd0 : tsel;

    for (genvar c = 0; c < NUM_CHAN; c++) begin : g_chan
        logic [ADDR_W-1:0] tc_addr;
        if (PAD_W > 0) begin : g_pad
            assign tc_addr = {tsel_eff, {PAD_W{1'b0}}, pix[c*CHAN_W +: CHAN_W]};
        end else begin : g_nopad
            assign tc_addr = {tsel_eff, pix[c*CHAN_W +: CHAN_W]};
        end
        assign bank_addr[c] = true_mode ? tc_addr : pix[ADDR_W-1:0];
    end
endmodule

// File: rtl/clut_bank.sv
module clut_bank #(
    parameter int ADDR_W = 11,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (en && we) mem[addr] <= wdata;
    end

    always_ff @(posedge clk) begin
        if (!rst_n)         rdata <= '0;
        else if (en && !we) rdata <= mem[addr];
    end
endmodule

// File: rtl/clut_sideband.sv
module clut_sideband #(
    parameter int SB_W = 4,
    parameter int LAT  = 3
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [SB_W-1:0] sync_in,
    input  logic [SB_W-1:0] cmd,
    output logic [SB_W-1:0] sync_out
);
    localparam int              AND_N    = SB_W / 2;
    localparam logic [SB_W-1:0] AND_MASK = SB_W'((64'd1 << AND_N) - 64'd1);
    localparam logic [SB_W-1:0] OR_MASK  = ~AND_MASK;
    localparam int              CW       = $clog2(LAT + 1);

    logic [SB_W-1:0] forced;
    logic [SB_W-1:0] stage [LAT];

    // low half cleared by mask zeros, high half set by mask ones
    assign forced = (sync_in & (cmd | OR_MASK)) | (cmd & OR_MASK);

    always_ff @(posedge clk) begin
        if (!rst_n) stage[0] <= '0;
        else        stage[0] <= forced;
    end

    for (genvar i = 1; i < LAT; i++) begin : g_dly
        always_ff @(posedge clk) begin
            if (!rst_n) stage[i] <= '0;
            else        stage[i] <= stage[i-1];
        end
    end

    assign sync_out = stage[LAT-1];

    // checker: how long the mask has been steady since reset
    logic [CW-1:0]   stab_cnt;
    logic [SB_W-1:0] cmd_prev;
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stab_cnt <= '0;
            cmd_prev <= '0;
        end else begin
            cmd_prev <= cmd;
            if (cmd != cmd_prev)          stab_cnt <= '0;
            else if (stab_cnt != CW'(LAT)) stab_cnt <= stab_cnt + 1'b1;
        end
    end

    a_r6_force_mask: assert property (@(posedge clk) disable iff (!rst_n)
        (stab_cnt == CW'(LAT) && cmd == cmd_prev) |->
            (((sync_out & ~cmd & AND_MASK) == '0) &&
             ((~sync_out & cmd & OR_MASK) == '0)))
        else $error("sideband force mask violated");
endmodule

// File: rtl/clut_datapath.sv
module clut_datapath
    import clut_pkg::*;
#(
    parameter int ADDR_W = 11,
    parameter int SB_W   = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [PIX_W-1:0]  pix_in,
    input  logic              true_mode,
    input  logic [SEL_W-1:0]  tbl_sel,
    input  logic [SB_W-1:0]   sync_in,
    input  logic [SB_W-1:0]   sync_force,
    input  logic              host_req,
    input  logic              host_we,
    input  logic [ADDR_W-1:0] host_addr,
    input  logic [PIX_W-1:0]  host_wdata,
    output logic [PIX_W-1:0]  host_rdata,
    input  logic              hold_req,
    output logic [PIX_W-1:0]  pix_out,
    output logic [SB_W-1:0]   sync_out
);
    localparam int PIPE_LAT = 3;

    logic pix_gnt, host_gnt, read_valid;

    clut_arbiter u_arb (
        .clk        (clk),
        .rst_n      (rst_n),
        .host_req   (host_req),
        .hold_req   (hold_req),
        .pix_gnt    (pix_gnt),
        .host_gnt   (host_gnt),
        .read_valid (read_valid)
    );

    // stage 1: pixel capture
    logic [PIX_W-1:0] pix_q;
    logic             mode_q;
    logic [SEL_W-1:0] tsel_q;
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pix_q  <= '0;
            mode_q <= 1'b0;
            tsel_q <= '0;
        end else begin
            pix_q  <= pix_in;
            mode_q <= true_mode;
            tsel_q <= tbl_sel;
        end
    end

    logic [ADDR_W-1:0] pix_addr [NUM_CHAN];
    clut_addr_gen #(.ADDR_W(ADDR_W)) u_agen (
        .pix       (pix_q),
        .true_mode (mode_q),
        .tsel      (tsel_q),
        .bank_addr (pix_addr)
    );

    // stage 2: bank read (host or pixel)
    logic [PIX_W-1:0] rd_word;
    for (genvar c = 0; c < NUM_CHAN; c++) begin : g_bank
        logic [CHAN_W-1:0] rd_c;
        clut_bank #(.ADDR_W(ADDR_W), .DATA_W(CHAN_W)) u_bank (
            .clk   (clk),
            .rst_n (rst_n),
            .en    (pix_gnt | host_gnt),
            .we    (host_gnt & host_we),
            .addr  (host_gnt ? host_addr : pix_addr[c]),
            .wdata (host_wdata[c*CHAN_W +: CHAN_W]),
            .rdata (rd_c)
        );
        assign rd_word[c*CHAN_W +: CHAN_W] = rd_c;
    end

    // stage 3: output register, frozen when the last read was not a pixel read
    always_ff @(posedge clk) begin
        if (!rst_n)          pix_out <= '0;
        else if (read_valid) pix_out <= rd_word;
    end

    logic host_rd_q;
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            host_rd_q  <= 1'b0;
            host_rdata <= '0;
        end else begin
            host_rd_q <= host_gnt & ~host_we;
            if (host_rd_q) host_rdata <= rd_word;
        end
    end

    clut_sideband #(.SB_W(SB_W), .LAT(PIPE_LAT)) u_sb (
        .clk      (clk),
        .rst_n    (rst_n),
        .sync_in  (sync_in),
        .cmd      (sync_force),
        .sync_out (sync_out)
    );

    a_r9_frozen_out: assert property (@(posedge clk) disable iff (!rst_n)
        !read_valid |=> $stable(pix_out))
        else $error("output moved while frozen");

    a_r8_rdata_keep: assert property (@(posedge clk) disable iff (!rst_n)
        !host_rd_q |=> $stable(host_rdata))
        else $error("host read data moved without a read");
endmodule

// File: tb/clut_datapath_bench.sv
`timescale 1ns/1ps
module clut_datapath_bench;
    localparam int AW    = 11;
    localparam int SBW   = 4;
    localparam int DEPTH = 1 << AW;
    localparam int NVEC  = 8;

    logic        clk = 1'b0;
    logic        rst_n;
    logic [23:0] pix_in;
    logic        true_mode;
    logic [1:0]  tbl_sel;
    logic [3:0]  sync_in, sync_force;
    logic        host_req, host_we, hold_req;
    logic [AW-1:0] host_addr;
    logic [23:0] host_wdata, host_rdata, pix_out;
    logic [3:0]  sync_out;

    int n_tests = 0;
    int n_fail  = 0;

    always #5 clk = ~clk;

    clut_datapath #(.ADDR_W(AW), .SB_W(SBW)) u_clut_datapath (
        .clk(clk), .rst_n(rst_n), .pix_in(pix_in), .true_mode(true_mode),
        .tbl_sel(tbl_sel), .sync_in(sync_in), .sync_force(sync_force),
        .host_req(host_req), .host_we(host_we), .host_addr(host_addr),
        .host_wdata(host_wdata), .host_rdata(host_rdata), .hold_req(hold_req),
        .pix_out(pix_out), .sync_out(sync_out)
    );

    // fill pattern: distinct per bank and address
    function automatic logic [7:0] fval(int b, int a);
        return 8'(((a * 37) + (b * 91) + (a >> 3)) ^ 32'h5A);
    endfunction

    function automatic logic [23:0] word_at(int a);
        return {fval(2, a), fval(1, a), fval(0, a)};
    endfunction

    function automatic logic [23:0] exp_color(logic m, logic [1:0] t, logic [23:0] p);
        logic [23:0] r;
        int t2;
        if (!m) return word_at(int'(p) & (DEPTH - 1));
        t2 = (t == 2'd3) ? 0 : int'(t);
        for (int c = 0; c < 3; c++)
            r[c*8 +: 8] = fval(c, (t2 << (AW - 2)) | int'(p[c*8 +: 8]));
        return r;
    endfunction

    task automatic chk(input string req, input logic [23:0] act, input logic [23:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // {true_mode, tbl_sel, pix, sync_in, sync_force, expected sync_out}
    localparam logic [38:0] VEC [NVEC] = '{
        {1'b0, 2'd0, 24'h000005, 4'h0, 4'hF, 4'hC},   // R2 R6
        {1'b0, 2'd2, 24'hFFF7FF, 4'hF, 4'h3, 4'hF},   // R2 top index, upper bits ignored
        {1'b0, 2'd0, 24'h123456, 4'h5, 4'h0, 4'h4},   // R2 R6
        {1'b1, 2'd0, 24'h00FF80, 4'hA, 4'h3, 4'hA},   // R3 table 0
        {1'b1, 2'd1, 24'h3C2D1E, 4'h3, 4'h1, 4'h1},   // R3 table 1
        {1'b1, 2'd2, 24'hFF0001, 4'h0, 4'h4, 4'h4},   // R3 table 2
        {1'b1, 2'd3, 24'h3C2D1E, 4'h6, 4'h8, 4'hC},   // R4 table 3 -> 0
        {1'b0, 2'd3, 24'h000800, 4'h9, 4'h2, 4'h8}    // R2 bit ADDR_W ignored
    };

    initial begin
        #(100000 * 10);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        rst_n = 1'b0; pix_in = '0; true_mode = 1'b0; tbl_sel = '0;
        sync_in = '0; sync_force = '0; host_req = 1'b0; host_we = 1'b0;
        host_addr = '0; host_wdata = '0; hold_req = 1'b0;
        repeat (3) @(negedge clk);
        chk("R1 pix_out", pix_out, 24'h0);
        chk("R1 sync_out", {20'h0, sync_out}, 24'h0);
        chk("R1 host_rdata", host_rdata, 24'h0);
        rst_n = 1'b1;

        // fill all banks through the host port
        host_req = 1'b1; host_we = 1'b1;
        for (int a = 0; a < DEPTH; a++) begin
            host_addr = AW'(a);
            host_wdata = word_at(a);
            @(negedge clk);
        end
        host_req = 1'b0; host_we = 1'b0;

        // vector walk: R2 R3 R4 R5 R6
        for (int v = 0; v < NVEC; v++) begin
            {true_mode, tbl_sel, pix_in, sync_in, sync_force} = VEC[v][38:4];
            repeat (3) @(negedge clk);
            chk("R2/R3/R4 color", pix_out,
                exp_color(VEC[v][38], VEC[v][37:36], VEC[v][35:12]));
            chk("R6 sideband", {20'h0, sync_out}, {20'h0, VEC[v][3:0]});
        end

        // R5 latency: old values two clocks in, new on the third
        true_mode = 1'b0; pix_in = 24'h0000AA; sync_in = 4'hF; sync_force = 4'hF;
        repeat (2) @(negedge clk);
        chk("R5 color not early", pix_out, exp_color(1'b0, 2'd3, 24'h000800));
        chk("R5 sideband not early", {20'h0, sync_out}, 24'h8);
        @(negedge clk);
        chk("R5 color at 3", pix_out, word_at(32'hAA));
        chk("R5 sideband at 3", {20'h0, sync_out}, 24'hF);

        // R8 host read
        host_req = 1'b1; host_we = 1'b0; host_addr = AW'(32'h123);
        @(negedge clk);
        host_req = 1'b0;
        @(negedge clk);
        chk("R8 host read", host_rdata, word_at(32'h123));

        // R7 host write wins over a simultaneous hold
        host_req = 1'b1; host_we = 1'b1; hold_req = 1'b1;
        host_addr = AW'(32'h456); host_wdata = 24'hABCDEF;
        @(negedge clk);
        host_req = 1'b0; host_we = 1'b0; hold_req = 1'b0;
        true_mode = 1'b0; pix_in = 24'h000456;
        repeat (3) @(negedge clk);
        chk("R7 written word seen", pix_out, 24'hABCDEF);

        // R9 and R11: freeze during host access, resume after two clocks
        pix_in = 24'h000005;
        repeat (3) @(negedge clk);
        chk("R2 steady pixel", pix_out, word_at(5));
        pix_in = 24'h000009; host_req = 1'b1; host_we = 1'b0; host_addr = '0;
        repeat (5) @(negedge clk);
        chk("R9 held during host", pix_out, word_at(5));
        host_req = 1'b0;
        repeat (2) @(negedge clk);
        chk("R11 resume after host", pix_out, word_at(9));

        // R10 and R11: hold request
        pix_in = 24'h000020; hold_req = 1'b1;
        repeat (4) @(negedge clk);
        chk("R10 held during hold", pix_out, word_at(9));
        hold_req = 1'b0;
        repeat (2) @(negedge clk);
        chk("R11 resume after hold", pix_out, word_at(32'h20));

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule